// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the software-visible register set for two bus-master DMA channels of a disk controller. Each channel has a command byte, a status byte and a 32-bit descriptor-table pointer. Software writes to the command byte are turned into one-cycle start and abort pulses for a drive-side DMA engine. The start pulse carries the channel's descriptor pointer.

The engine signals the end of a transfer with a per-channel completion input. That input stops the channel and raises its interrupt. Reads are combinational and return one, two or four bytes, little-endian, from any offset. Writes only take effect while the bus-master-enable input is high. Address decode of the enclosing bus, descriptor fetching and the engine itself lie outside the block.

Top module: `bmdma_regs`

## Requirements
- R1: After a synchronous reset, every status byte reads 0x60 (DMA-capable bits 5 and 6 set), command bytes and pointers read zero, and dma_start, dma_abort and irq are low.
- R2: Channel c occupies byte offsets c*8 to c*8+7: command at +0, status at +2, pointer at +4..+7; bytes +1 and +3 read zero. A read with rd_size 0 (byte), 1 (half) or 2 (word) returns the bytes from rd_addr upward, little-endian; bytes past the last offset read zero.
- R3: A command write takes effect only with wr_size 0 (byte). It stores bit 0 (run) and bit 3 (direction), and the other bits read zero. Command writes of any other size are ignored.
- R4: While run is set, a command write leaves the direction bit at its old value.
- R5: A command write that changes run from 0 to 1 sets status bit 0 (active). In the cycle after the write edge, it raises that channel's dma_start for one cycle, with dma_start_ptr equal to the channel pointer.
- R6: A command write that changes run from 1 to 0 clears active and raises that channel's dma_abort for one cycle.
- R7: Status writes take effect only as byte writes. Active is read-only. Error (bit 1) and interrupt (bit 2) clear only when 1 is written while they are set, and are never set by a write. Bits 5 and 6 are plain read/write, and all other bits read zero.
- R8: The pointer accepts only word (wr_size 2) writes at offset +4, with bits 1:0 forced to zero. Writes of other sizes are ignored.
- R9: A dma_done pulse for a channel clears run and active and sets the interrupt bit, with priority over a same-cycle write.
- R10: irq for each channel equals its status interrupt bit.
- R11: While bm_en is low, every write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bm_en | input | 1 | Bus-master enable; writes are ignored when low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write byte offset |
| wr_size | input | 2 | Write size: 0 byte, 1 half, 2 word |
| wr_data | input | 32 | Write data, right-aligned |
| rd_addr | input | 4 | Read byte offset |
| rd_size | input | 2 | Read size: 0 byte, 1 half, 2 word |
| rd_data | output | 32 | Read data, little-endian, zero-extended |
| dma_done | input | 2 | Per-channel transfer-complete pulse |
| dma_start | output | 2 | Per-channel start pulse |
| dma_abort | output | 2 | Per-channel abort pulse |
| dma_start_ptr | output | 64 | Per-channel descriptor pointer sent with start |
| irq | output | 2 | Per-channel interrupt |

## Verification
The bench builds the block with its default of two channels. With two channels, a second channel's pointer, status and completion path can be seen changing independently of the first. It also makes the top of the 16-byte window reachable, where wide reads run past the last byte. Stimulus covers start, abort, the locked direction bit, completion, the write-one-to-clear interrupt, writes of wrong size and writes while disabled.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    localparam int CH_BYTES   = 8;
    localparam int OFS_CMD    = 0;
    localparam int OFS_STS    = 2;
    localparam int OFS_PTR    = 4;

    localparam int CMD_RUN    = 0;
    localparam int CMD_DIR    = 3;

    localparam int STS_ACT    = 0;
    localparam int STS_ERR    = 1;
    localparam int STS_IRQ    = 2;
    localparam int STS_CAP0   = 5;
    localparam int STS_CAP1   = 6;

    typedef struct packed {
        logic run;
        logic dir;
    } cmd_t;

    typedef struct packed {
        logic cap1;
        logic cap0;
        logic irq;
        logic err;
        logic act;
    } sts_t;

    function automatic logic [7:0] cmd_to_byte(cmd_t c);
        logic [7:0] b;
        b = '0;
        b[CMD_RUN] = c.run;
        b[CMD_DIR] = c.dir;
        return b;
    endfunction

    function automatic logic [7:0] sts_to_byte(sts_t s);
        logic [7:0] b;
        b = '0;
        b[STS_ACT]  = s.act;
        b[STS_ERR]  = s.err;
        b[STS_IRQ]  = s.irq;
        b[STS_CAP0] = s.cap0;
        b[STS_CAP1] = s.cap1;
        return b;
    endfunction

    function automatic int size_bytes(logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/bmdma_wr_decode.sv
module bmdma_wr_decode
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic              bm_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    output logic [NUM_CH-1:0] cmd_we,
    output logic [NUM_CH-1:0] sts_we,
    output logic [NUM_CH-1:0] ptr_we
);
    logic go;
    assign go = wr_en && bm_en;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        localparam int BASE = c * CH_BYTES;
        assign cmd_we[c] = go && (wr_size == SZ_BYTE) &&
                           (wr_addr == ADDR_W'(BASE + OFS_CMD));
        assign sts_we[c] = go && (wr_size == SZ_BYTE) &&
                           (wr_addr == ADDR_W'(BASE + OFS_STS));
        assign ptr_we[c] = go && (wr_size == SZ_WORD) &&
                           (wr_addr == ADDR_W'(BASE + OFS_PTR));
    end

endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
    import bmdma_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic             sts_we,
    input  logic             ptr_we,
    input  logic [PTR_W-1:0] wdata,
    input  logic             done,
    output logic [7:0]       cmd_byte,
    output logic [7:0]       sts_byte,
    output logic [PTR_W-1:0] ptr,
    output logic             start_pulse,
    output logic             abort_pulse,
    output logic [PTR_W-1:0] start_ptr,
    output logic             irq
);
    cmd_t             cmd_q;
    sts_t             sts_q;
    logic [PTR_W-1:0] ptr_q;
    logic             going_up, going_down;

    assign going_up   = cmd_we && !cmd_q.run &&  wdata[CMD_RUN];
    assign going_down = cmd_we &&  cmd_q.run && !wdata[CMD_RUN];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q       <= '0;
            sts_q       <= '{cap1: 1'b1, cap0: 1'b1, irq: 1'b0, err: 1'b0, act: 1'b0};
            ptr_q       <= '0;
            start_pulse <= 1'b0;
            abort_pulse <= 1'b0;
            start_ptr   <= '0;
        end else begin
            start_pulse <= going_up;
            abort_pulse <= going_down;
            if (going_up)
                start_ptr <= ptr_q;
            if (cmd_we) begin
                cmd_q.run <= wdata[CMD_RUN];
                cmd_q.dir <= cmd_q.run ? cmd_q.dir : wdata[CMD_DIR];
                if (going_up)
                    sts_q.act <= 1'b1;
                if (going_down)
                    sts_q.act <= 1'b0;
            end
            if (sts_we) begin
                sts_q.err  <= sts_q.err & ~wdata[STS_ERR];
                sts_q.irq  <= sts_q.irq & ~wdata[STS_IRQ];
                sts_q.cap0 <= wdata[STS_CAP0];
                sts_q.cap1 <= wdata[STS_CAP1];
            end
            if (ptr_we)
                ptr_q <= {wdata[PTR_W-1:2], 2'b00};
            if (done) begin
                cmd_q.run <= 1'b0;
                sts_q.act <= 1'b0;
                sts_q.irq <= 1'b1;
            end
        end
    end

    assign cmd_byte = cmd_to_byte(cmd_q);
    assign sts_byte = sts_to_byte(sts_q);
    assign ptr      = ptr_q;
    assign irq      = sts_q.irq;

    AST_DIR_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_q.run) |=> (cmd_q.dir == $past(cmd_q.dir))); // R4

    AST_START_SETS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (going_up && !done) |=> (start_pulse && sts_q.act && start_ptr == $past(ptr_q))); // R5

    AST_STOP_CLEARS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        going_down |=> (abort_pulse && !sts_q.act)); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sts_q.irq && !(sts_we && wdata[STS_IRQ])) |=> sts_q.irq); // R7

    AST_IRQ_NOT_SET_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!sts_q.irq && !done) |=> !sts_q.irq); // R7

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ptr_we |=> $stable(ptr_q)); // R8

    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (rst)
        done |=> (!cmd_q.run && !sts_q.act && sts_q.irq)); // R9

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(start_pulse && abort_pulse)); // R5

endmodule

// File: rtl/bmdma_rd_mux.sv
module bmdma_rd_mux
    import bmdma_pkg::*;
#(
    parameter int NUM_BYTES = 16,
    parameter int ADDR_W    = 4
) (
    input  logic [NUM_BYTES*8-1:0] image,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [1:0]             rd_size,
    output logic [31:0]            rd_data
);
    always_comb begin
        int nb;
        nb = size_bytes(rd_size);
        rd_data = '0;
        for (int k = 0; k < 4; k++) begin
            int idx;
            idx = int'(rd_addr) + k;
            if (k < nb && idx < NUM_BYTES)
                rd_data[k*8 +: 8] = image[idx*8 +: 8];
        end
    end

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int PTR_W  = 32,
    localparam int NUM_BYTES = NUM_CH * CH_BYTES,
    localparam int ADDR_W    = $clog2(NUM_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bm_en,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [1:0]              wr_size,
    input  logic [PTR_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [1:0]              rd_size,
    output logic [31:0]             rd_data,
    input  logic [NUM_CH-1:0]       dma_done,
    output logic [NUM_CH-1:0]       dma_start,
    output logic [NUM_CH-1:0]       dma_abort,
    output logic [NUM_CH*PTR_W-1:0] dma_start_ptr,
    output logic [NUM_CH-1:0]       irq
);
    logic [NUM_CH-1:0]      cmd_we, sts_we, ptr_we;
    logic [NUM_BYTES*8-1:0] image;
    logic [NUM_CH*8-1:0]    all_cmd, all_sts;

    bmdma_wr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_dec (
        .wr_en   (wr_en),
        .bm_en   (bm_en),
        .wr_addr (wr_addr),
        .wr_size (wr_size),
        .cmd_we  (cmd_we),
        .sts_we  (sts_we),
        .ptr_we  (ptr_we)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [7:0]       cmd_b, sts_b;
        logic [PTR_W-1:0] ptr_v;

        bmdma_chan #(.PTR_W(PTR_W)) i_chan (
            .clk         (clk),
            .rst         (rst),
            .cmd_we      (cmd_we[c]),
            .sts_we      (sts_we[c]),
            .ptr_we      (ptr_we[c]),
            .wdata       (wr_data),
            .done        (dma_done[c]),
            .cmd_byte    (cmd_b),
            .sts_byte    (sts_b),
            .ptr         (ptr_v),
            .start_pulse (dma_start[c]),
            .abort_pulse (dma_abort[c]),
            .start_ptr   (dma_start_ptr[c*PTR_W +: PTR_W]),
            .irq         (irq[c])
        );

        assign image[c*64 +: 64] = {ptr_v, 8'h00, sts_b, 8'h00, cmd_b};
        assign all_cmd[c*8 +: 8] = cmd_b;
        assign all_sts[c*8 +: 8] = sts_b;
    end

    bmdma_rd_mux #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) i_rd (
        .image   (image),
        .rd_addr (rd_addr),
        .rd_size (rd_size),
        .rd_data (rd_data)
    );

    AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !bm_en && dma_done == '0) |=> ($stable(all_cmd) && $stable(all_sts))); // R11

    AST_IRQ_MIRRORS_STATUS: assert property (@(posedge clk) disable iff (rst)
        dma_done[0] |=> irq[0]); // R10

endmodule

// File: tb/test_bmdma_regs.sv
module test_bmdma_regs;
    logic        clk = 1'b0;
    logic        rst;
    logic        bm_en, wr_en;
    logic [3:0]  wr_addr, rd_addr;
    logic [1:0]  wr_size, rd_size;
    logic [31:0] wr_data, rd_data;
    logic [1:0]  dma_done, dma_start, dma_abort, irq;
    logic [63:0] dma_start_ptr;

    int errors = 0;
    int checks = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    bmdma_regs i_bmdma_regs (
        .clk(clk), .rst(rst), .bm_en(bm_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(rd_data),
        .dma_done(dma_done), .dma_start(dma_start), .dma_abort(dma_abort),
        .dma_start_ptr(dma_start_ptr), .irq(irq)
    );

    // vector: op(1: 1=write 0=read) req(4) addr(4) size(2) data(32) exp(32)
    localparam int NV = 17;
    localparam logic [74:0] VEC [NV] = '{
        {1'b1, 4'd8, 4'h4, 2'd2, 32'h12345677, 32'h0},        // R8 ptr write
        {1'b0, 4'd8, 4'h4, 2'd2, 32'h0,        32'h12345674},
        {1'b1, 4'd8, 4'h4, 2'd1, 32'h0000FFFF, 32'h0},        // R8 half ignored
        {1'b0, 4'd8, 4'h4, 2'd2, 32'h0,        32'h12345674},
        {1'b1, 4'd8, 4'hC, 2'd2, 32'hAABBCCDD, 32'h0},        // R8 channel 1
        {1'b0, 4'd8, 4'hC, 2'd2, 32'h0,        32'hAABBCCDC},
        {1'b0, 4'd2, 4'h6, 2'd1, 32'h0,        32'h00001234}, // R2 half read
        {1'b1, 4'd3, 4'h0, 2'd0, 32'h000000FE, 32'h0},        // R3 bits kept: dir only
        {1'b0, 4'd3, 4'h0, 2'd0, 32'h0,        32'h00000008},
        {1'b1, 4'd3, 4'h0, 2'd1, 32'h00000001, 32'h0},        // R3 half ignored
        {1'b0, 4'd3, 4'h0, 2'd0, 32'h0,        32'h00000008},
        {1'b0, 4'd2, 4'h0, 2'd2, 32'h0,        32'h00600008}, // R2 word read
        {1'b1, 4'd7, 4'h2, 2'd0, 32'h00000000, 32'h0},        // R7 caps writable
        {1'b0, 4'd7, 4'h2, 2'd0, 32'h0,        32'h00000000},
        {1'b1, 4'd7, 4'h2, 2'd0, 32'h000000FF, 32'h0},        // R7 act/err/irq not settable
        {1'b0, 4'd7, 4'h2, 2'd0, 32'h0,        32'h00000060},
        {1'b0, 4'd2, 4'hE, 2'd2, 32'h0,        32'h0000AABB}  // R2 read past end
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_size = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic [1:0] s, output logic [31:0] d);
        rd_addr = a; rd_size = s;
        #1;
        d = rd_data;
    endtask

    task automatic done_pulse(logic [1:0] m);
        @(negedge clk);
        dma_done = m;
        @(negedge clk);
        dma_done = 2'b00;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; bm_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_size = '0;
        wr_data = '0; rd_addr = '0; rd_size = '0; dma_done = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'h0, 2'd2, d); chk("R1 ch0 cmd/sts", d, 32'h00600000);
        rd(4'h8, 2'd2, d); chk("R1 ch1 cmd/sts", d, 32'h00600000);
        rd(4'h4, 2'd2, d); chk("R1 ch0 ptr", d, 32'h0);
        chk("R1 outputs", {26'h0, dma_start, dma_abort, irq}, 32'h0);

        // R11 disabled writes
        wr(4'h4, 2'd2, 32'hDEADBEEF);
        rd(4'h4, 2'd2, d); chk("R11 ptr write ignored", d, 32'h0);
        wr(4'h0, 2'd0, 32'h01);
        chk("R11 no start", {30'h0, dma_start}, 32'h0);
        rd(4'h0, 2'd0, d); chk("R11 cmd unchanged", d, 32'h0);

        bm_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [74:0] v;
            v = VEC[i];
            if (v[74]) begin
                wr(v[69:66], v[65:64], v[63:32]);
            end else begin
                rd(v[69:66], v[65:64], d);
                checks++;
                if (d !== v[31:0]) begin
                    errors++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h",
                             v[73:70], i, d, v[31:0]);
                end
            end
        end
        wr(4'h2, 2'd0, 32'h60);

        // R5 start: cmd 0x09 -> run with dir
        wr(4'h0, 2'd0, 32'h09);
        chk("R5 start pulse", {30'h0, dma_start}, 32'h1);
        chk("R5 start ptr", dma_start_ptr[31:0], 32'h12345674);
        rd(4'h2, 2'd0, d); chk("R5 active set", d, 32'h61);
        @(negedge clk);
        chk("R5 pulse one cycle", {30'h0, dma_start}, 32'h0);

        // R4 direction locked
        wr(4'h0, 2'd0, 32'h01);
        rd(4'h0, 2'd0, d); chk("R4 dir kept", d, 32'h09);
        chk("R4 no extra pulse", {28'h0, dma_start, dma_abort}, 32'h0);

        // R6 stop
        wr(4'h0, 2'd0, 32'h00);
        chk("R6 abort pulse", {30'h0, dma_abort}, 32'h1);
        rd(4'h0, 2'd2, d); chk("R6 active clear", d, 32'h00600008);

        // R9 completion
        wr(4'h0, 2'd0, 32'h01);
        done_pulse(2'b01);
        rd(4'h0, 2'd2, d); chk("R9 done clears run/act sets irq", d, 32'h00640000);
        chk("R10 irq ch0", {30'h0, irq}, 32'h1);

        // R7 write-one-to-clear
        wr(4'h2, 2'd0, 32'h60);
        rd(4'h2, 2'd0, d); chk("R7 irq kept on zero write", d, 32'h64);
        wr(4'h2, 2'd0, 32'h64);
        rd(4'h2, 2'd0, d); chk("R7 irq cleared by one", d, 32'h60);
        chk("R10 irq low", {30'h0, irq}, 32'h0);

        // R9 priority over same-cycle start write, channel 1
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'h8; wr_size = 2'd0; wr_data = 32'h01; dma_done = 2'b10;
        @(negedge clk);
        wr_en = 1'b0; dma_done = 2'b00;
        rd(4'h8, 2'd2, d); chk("R9 done wins", d, 32'h00640000);
        chk("R10 irq ch1 only", {30'h0, irq}, 32'h2);

        // R11 disabled again
        bm_en = 1'b0;
        wr(4'hA, 2'd0, 32'h04);
        chk("R11 irq not cleared", {30'h0, irq}, 32'h2);

        finish_run();
    end

endmodule